// File: doc/BRIEF.md
# Segmented Sampling-Depth and Event Slot Controller

This block governs eight recording segments of a switched-capacitor sampler, each segment holding a fixed number of cells (1024 by default). A write wave runs through the cells of a segment at one cell per clock. In chained mode the segments form groups, and when one segment writes its last cell the wave passes into the next segment of the same group. This gives channels of one, two, four or eight segments.

In event-buffer mode each segment is one event slot. Triggers fill the slots in a fixed rotation. A reader drains the slots in the same rotation while later slots are still recording, so the block holds up to eight events before it has to refuse a trigger.

A pulse on the cascade output marks the moment the last segment finishes. It can start the next device in a serial chain. Mode and partition inputs are changed only while no segment is writing.

Top module: `seg_chain_mgr`

## Requirements
- R1: After reset, wr_en, seg_full, rd_seg, rd_valid, evt_full, busy and cascade_out are all zero.
- R2: part_mode selects the group size as 2 to the power part_mode: 00 gives 8 groups of 1, 01 gives 4 of 2, 10 gives 2 of 4, 11 gives 1 of 8. With buf_mode=0, an accepted start enables the segments whose index is a multiple of the group size and clears every seg_full bit.
- R3: An enabled segment stays enabled for exactly CELLS cycles. Its seg_full bit is set in the cycle after its last cell.
- R4: With buf_mode=0, when a segment that is not the last of its group finishes, the next segment index is enabled in the very next cycle. No wave crosses a group boundary, and with part_mode=00 no wave is passed at all.
- R5: A start that arrives while busy is high (any segment enabled) is ignored in both modes.
- R6: cascade_out is high for exactly one cycle, the cycle after segment NSEG-1 writes its last cell.
- R7: With buf_mode=1, an accepted start enables exactly one segment. Slots are taken in rotation 0,1,...,NSEG-1,0.
- R8: With buf_mode=1, seg_full bit i marks slot i as completed and not yet released. rd_seg names the oldest such slot, and rd_valid is high when that slot holds data.
- R9: A rd_done pulse while rd_valid is high clears the seg_full bit of slot rd_seg and advances rd_seg by one, modulo NSEG. A rd_done pulse while rd_valid is low has no effect.
- R10: evt_full is high when all NSEG slots hold unread events. A start is refused while it is high.
- R11: A slot can be released by rd_done while another slot is being written, and the write continues unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_mode | input | 1 | 1: event-buffer mode, 0: chained-depth mode |
| part_mode | input | 2 | Partition select for chained mode |
| start | input | 1 | Trigger to start recording |
| rd_done | input | 1 | Reader has finished the slot named by rd_seg |
| wr_en | output | NSEG | Per-segment write enable |
| seg_full | output | NSEG | Per-segment completed/unread flag |
| rd_seg | output | log2(NSEG) | Slot to read next |
| rd_valid | output | 1 | rd_seg holds an unread event |
| evt_full | output | 1 | All slots hold unread events |
| busy | output | 1 | Some segment is writing |
| cascade_out | output | 1 | Last segment completed (one cycle) |

## Verification
The hardest states to reach from the ports are a read release that lands in the middle of a slot write, and a completely full buffer whose pointers have wrapped. The bench builds a random mix of triggers and releases from a fixed seed. Some triggers carry a release pulse two cycles into the write, and a directed phase fills all eight slots, tries one more trigger, drains the buffer and then pulses a release with nothing stored. Each chained partition is also run through all of its hand-offs, with a stray trigger injected mid-run.

// File: rtl/seg_chain_mgr.sv
module seg_chain_mgr #(
  parameter int NSEG  = 8,
  parameter int CELLS = 1024,
  localparam int SEGW = $clog2(NSEG),
  localparam int CW   = $clog2(CELLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            buf_mode,
  input  logic [1:0]      part_mode,
  input  logic            start,
  input  logic            rd_done,
  output logic [NSEG-1:0] wr_en,
  output logic [NSEG-1:0] seg_full,
  output logic [SEGW-1:0] rd_seg,
  output logic            rd_valid,
  output logic            evt_full,
  output logic            busy,
  output logic            cascade_out
);
  localparam logic [CW-1:0] LAST = CW'(CELLS - 1);

  logic [NSEG-1:0] act_q, act_d, done_q, done_d;
  logic [CW-1:0]   cnt_q [NSEG];
  logic [CW-1:0]   cnt_d [NSEG];
  logic [SEGW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic            casc_q, casc_d;
  logic [3:0]      grp_sz;

  assign grp_sz      = 4'd1 << part_mode;
  assign wr_en       = act_q;
  assign seg_full    = done_q;
  assign rd_seg      = rd_q;
  assign busy        = |act_q;
  assign rd_valid    = buf_mode & done_q[rd_q];
  assign evt_full    = buf_mode & (&done_q);
  assign cascade_out = casc_q;

  always_comb begin
    act_d  = act_q;
    done_d = done_q;
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    rd_d   = rd_q;
    casc_d = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      if (act_q[i]) begin
        if (cnt_q[i] == LAST) begin
          act_d[i]  = 1'b0;
          done_d[i] = 1'b1;
          if (i == NSEG - 1) casc_d = 1'b1;
          if (!buf_mode && (((i + 1) % int'(grp_sz)) != 0)) begin
            act_d[(i + 1) % NSEG] = 1'b1;
            cnt_d[(i + 1) % NSEG] = '0;
          end
        end else begin
          cnt_d[i] = cnt_q[i] + 1'b1;
        end
      end
    end
    if (start && !busy) begin
      if (!buf_mode) begin
        done_d = '0;
        for (int i = 0; i < NSEG; i++)
          if ((i % int'(grp_sz)) == 0) begin
            act_d[i] = 1'b1;
            cnt_d[i] = '0;
          end
      end else if (!done_q[wr_q]) begin
        act_d[wr_q] = 1'b1;
        cnt_d[wr_q] = '0;
        wr_d        = wr_q + 1'b1;
      end
    end
    if (buf_mode && rd_done && done_q[rd_q]) begin
      done_d[rd_q] = 1'b0;
      rd_d         = rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      done_q <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      casc_q <= 1'b0;
      for (int i = 0; i < NSEG; i++) cnt_q[i] <= '0;
    end else begin
      act_q  <= act_d;
      done_q <= done_d;
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      casc_q <= casc_d;
      cnt_q  <= cnt_d;
    end
  end

  p_single_writer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode |-> $onehot0(wr_en));

  p_refuse_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode && evt_full && start |=> !busy);

  p_release_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode && rd_done && rd_valid |=> rd_seg == SEGW'($past(rd_seg) + 1'b1));

  p_cascade_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_out |-> $past(wr_en[NSEG-1]) && !wr_en[NSEG-1]);

  for (genvar g = 0; g < NSEG; g++) begin : g_chk
    p_full_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seg_full[g]) |-> $fell(wr_en[g]));
    if (g < NSEG - 1) begin : g_link
      p_handoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_mode && !start && $fell(wr_en[g]) && (((g + 1) % int'(grp_sz)) != 0)
        |-> wr_en[g+1]);
    end
  end
endmodule

// File: tb/tb_seg_chain_mgr.sv
module tb_seg_chain_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG  = 8;
  localparam int CELLS = 16;

  logic clk = 1'b0, rst_n = 1'b0, buf_mode = 1'b0, start = 1'b0, rd_done = 1'b0;
  logic [1:0] part_mode = 2'd0;
  logic [NSEG-1:0] wr_en, seg_full;
  logic [2:0] rd_seg;
  logic rd_valid, evt_full, busy, cascade_out;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int m_wr = 0, m_rd = 0, m_cnt = 0;

  seg_chain_mgr #(.NSEG(NSEG), .CELLS(CELLS)) dut (
    .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode), .part_mode(part_mode),
    .start(start), .rd_done(rd_done), .wr_en(wr_en), .seg_full(seg_full),
    .rd_seg(rd_seg), .rd_valid(rd_valid), .evt_full(evt_full), .busy(busy),
    .cascade_out(cascade_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int a, input int e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, a, e);
    end
  endtask

  function automatic logic [NSEG-1:0] chain_en(int m, int t);
    int g = 1 << m;
    int p = t / CELLS;
    logic [NSEG-1:0] r = '0;
    if (p < g) for (int k = 0; k < NSEG / g; k++) r[k*g + p] = 1'b1;
    return r;
  endfunction

  function automatic logic [NSEG-1:0] chain_full(int m, int t);
    int g = 1 << m;
    logic [NSEG-1:0] r = '0;
    for (int i = 0; i < NSEG; i++) if (t >= ((i % g) + 1) * CELLS) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [NSEG-1:0] unread_mask(int rd, int cnt);
    logic [NSEG-1:0] r = '0;
    for (int k = 0; k < cnt; k++) r[(rd + k) % NSEG] = 1'b1;
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_wr = 0; m_rd = 0; m_cnt = 0;
  endtask

  task automatic run_chain(input int m);
    int g = 1 << m;
    part_mode = 2'(m);
    buf_mode = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int t = 0; t <= g*CELLS + 1; t++) begin
      if (t == 4) start = 1'b0;
      chk(wr_en == chain_en(m, t), (t == 4) ? "R5" : (g > 1 ? "R4" : "R2"), "chain wr_en", wr_en, chain_en(m, t));
      chk(seg_full == chain_full(m, t), "R3", "chain seg_full", seg_full, chain_full(m, t));
      chk(cascade_out == (t == g*CELLS), "R6", "cascade_out", cascade_out, (t == g*CELLS));
      if (t == 3) start = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic buf_trigger(input bit with_rd);
    bit acc = (m_cnt < NSEG);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int t = 0; t <= CELLS; t++) begin
      logic [NSEG-1:0] e = (acc && t < CELLS) ? (NSEG'(1) << m_wr) : '0;
      if (t == 2 && with_rd) begin
        rd_done = 1'b0;
        if (m_cnt > 0) begin m_rd = (m_rd + 1) % NSEG; m_cnt--; end
        chk(rd_seg == 3'(m_rd), "R11", "rd_seg during write", rd_seg, m_rd);
        chk(seg_full == unread_mask(m_rd, m_cnt), "R11", "seg_full during write", seg_full, unread_mask(m_rd, m_cnt));
      end
      chk(wr_en == e, acc ? "R7" : "R10", "buffer wr_en", wr_en, e);
      if (t == 1 && with_rd) rd_done = 1'b1;
      if (t < CELLS) @(negedge clk);
    end
    if (acc) begin m_wr = (m_wr + 1) % NSEG; m_cnt++; end
    chk(seg_full == unread_mask(m_rd, m_cnt), "R8", "seg_full after event", seg_full, unread_mask(m_rd, m_cnt));
    chk(evt_full == (m_cnt == NSEG), "R10", "evt_full", evt_full, (m_cnt == NSEG));
    chk(rd_valid == (m_cnt > 0), "R8", "rd_valid", rd_valid, (m_cnt > 0));
  endtask

  task automatic buf_read();
    @(negedge clk) rd_done = 1'b1;
    @(negedge clk) rd_done = 1'b0;
    if (m_cnt > 0) begin m_rd = (m_rd + 1) % NSEG; m_cnt--; end
    chk(rd_seg == 3'(m_rd), "R9", "rd_seg after release", rd_seg, m_rd);
    chk(seg_full == unread_mask(m_rd, m_cnt), "R9", "seg_full after release", seg_full, unread_mask(m_rd, m_cnt));
    chk(rd_valid == (m_cnt > 0), "R8", "rd_valid after release", rd_valid, (m_cnt > 0));
    chk(evt_full == (m_cnt == NSEG), "R10", "evt_full after release", evt_full, (m_cnt == NSEG));
  endtask

  initial begin
    int seed = 32'h5eed_0042;
    void'($urandom(seed));
    do_reset();
    chk(wr_en == 0 && seg_full == 0 && !busy, "R1", "reset vectors", {wr_en, seg_full}, 0);
    chk(rd_seg == 0 && !rd_valid && !evt_full && !cascade_out, "R1", "reset flags",
        {rd_seg, rd_valid, evt_full, cascade_out}, 0);
    for (int m = 0; m < 4; m++) run_chain(m);
    run_chain(1);
    do_reset();
    buf_mode = 1'b1;
    @(negedge clk);
    buf_read();
    for (int k = 0; k < NSEG; k++) buf_trigger(1'b0);
    buf_trigger(1'b0);
    for (int k = 0; k < NSEG; k++) buf_read();
    buf_read();
    for (int k = 0; k < 60; k++) begin
      int r = $urandom_range(0, 9);
      if (r < 5) buf_trigger(r < 2);
      else buf_read();
    end
    for (int k = 0; k < 10; k++) buf_trigger(1'b0);
    for (int k = 0; k < 3; k++) buf_trigger(1'b1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule